// File: doc/BRIEF.md
# Head-Per-Track Disk Command Decoder

This block sits between a 12-bit minicomputer's programmed-I/O bus and the transfer engine of a head-per-track disk controller. Each bus instruction arrives as a one-cycle strobe. The strobe carries a device code, three pulse bits and the current accumulator. The block answers one cycle later with a new accumulator value and a skip flag.

The block owns the controller status word, the low 12 bits of the disk address, the done flag and the interrupt request. It raises a one-cycle start pulse, with a read/write indication, for the transfer engine. The engine in turn reports completion and error events back to it.

The three recognised device codes are parameters. On a recognised code the pulse bits of one instruction act in a fixed order and their effects combine. Any other code is ignored. A rotational word-position input and a photocell input come from the disk side.

Top module: `diskIotFront`

## Requirements
- R1: While reset is asserted and after it is released: the disk address, extension fields and error bits are 0, done is 1, the interrupt request is 0, and respValid, skip, accOut and xferStart are 0.
- R2: A strobe with one of the three device codes produces respValid, accOut and skip exactly one clock later, for one cycle. A strobe with any other code produces no response and changes no state. When no response is due, accOut and skip are 0.
- R3: Code A with pulse bit 0 set clears the disk address, the done flag, the three error bits and the interrupt request.
- R4: Code A with pulse bit 1 or bit 2 ORs accIn into the disk address and pulses xferStart one cycle later. xferWrite equals pulse bit 2. accOut is 0. With bits 0 and 1 together, the address is cleared first and then loaded.
- R5: Code B pulse bit 0 clears both extension fields. Pulse bit 2 ORs accIn bits 10..3 into status bits 10..3 and returns accIn ORed with the status value sampled before the instruction. With bits 0 and 2 together, the fields are cleared and then loaded.
- R6: Code B pulse bit 1 returns accOut = 0. It skips when the low 11 bits of the disk address equal rotPos; disk address bit 11 takes no part in the comparison.
- R7: Code C pulse bit 0 skips when all three error bits (status bits 2..0) are 0.
- R8: Code C pulse bit 1 without bit 2 skips when done is set. Pulse bit 2 ORs the disk address into the returned value. With bits 1 and 2 together, the accumulator is zeroed first and no done skip occurs.
- R9: A completion pulse (xferDone) sets done and the interrupt request. If it arrives in the same cycle as a clear command, it takes precedence. errSet bits are ORed into status bits 2..0 (bit 2 data late, bit 1 write-lock, bit 0 parity).
- R10: The interrupt request falls only through reset or a code A pulse-bit-0 command.
- R11: statusOut bit 11 follows the photocell input. Bits 10..6 are the disk extension, bits 5..3 the memory extension and bits 2..0 the errors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| iotStrobe | input | 1 | One-cycle I/O instruction strobe |
| devCode | input | 6 | Device code of the instruction |
| pulse | input | 3 | Pulse bits of the instruction |
| accIn | input | 12 | Accumulator value on the bus |
| rotPos | input | 11 | Current rotational word position |
| photocell | input | 1 | Photocell sense line |
| xferDone | input | 1 | Transfer engine completion pulse |
| errSet | input | 3 | Error events from the engine (late, write-lock, parity) |
| respValid | output | 1 | Response presented this cycle |
| accOut | output | 12 | Returned accumulator value |
| skip | output | 1 | Skip request |
| xferStart | output | 1 | Start pulse to the transfer engine |
| xferWrite | output | 1 | 1 = write, 0 = read, valid with xferStart |
| diskAddr | output | 12 | Low disk address register |
| statusOut | output | 12 | Status word |
| doneFlag | output | 1 | Done flag |
| irq | output | 1 | Interrupt request |

## Verification
The bus response (respValid, accOut, skip) and the xferStart pulse are due one clock after the strobe edge. Register effects on diskAddr, doneFlag, irq and the error bits become visible at that same edge. statusOut bit 11 follows the photocell input with no delay. The bench drives inputs on the falling edge and compares every output with its behavioural model a quarter period after each rising edge. Directed checks are sampled at the following falling edge, while the one-cycle response is still held.

// File: rtl/diskIotPkg.sv
package diskIotPkg;
  localparam int PULSE_W = 3;
  localparam int ERR_W   = 3;
  localparam int MEXT_W  = 3;
  localparam int DEXT_W  = 5;
  localparam int EXT_LSB = ERR_W;
  localparam int EXT_W   = MEXT_W + DEXT_W;

  typedef struct packed {
    logic respond;
    logic clrCtl;
    logic loadDa;
    logic startXfer;
    logic isWrite;
    logic clrExt;
    logic loadExt;
    logic zeroAcc;
    logic orStatus;
    logic orDa;
    logic chkCoin;
    logic chkErr;
    logic chkDone;
  } ctrlStrobes_t;
endpackage

// File: rtl/diskIotCtrl.sv
module diskIotCtrl
  import diskIotPkg::*;
#(
  parameter int DEV_W = 6,
  parameter logic [DEV_W-1:0] DEV_A = 6'o60,
  parameter logic [DEV_W-1:0] DEV_B = 6'o61,
  parameter logic [DEV_W-1:0] DEV_C = 6'o62
) (
  input  logic               iotStrobe,
  input  logic [DEV_W-1:0]   devCode,
  input  logic [PULSE_W-1:0] pulse,
  output ctrlStrobes_t       strb
);
  logic hitA, hitB, hitC;

  assign hitA = iotStrobe && (devCode == DEV_A);
  assign hitB = iotStrobe && (devCode == DEV_B);
  assign hitC = iotStrobe && (devCode == DEV_C);

  always_comb begin
    strb = '0;
    if (hitA) begin
      strb.respond   = 1'b1;
      strb.clrCtl    = pulse[0];
      strb.loadDa    = pulse[1] | pulse[2];
      strb.startXfer = pulse[1] | pulse[2];
      strb.isWrite   = pulse[2];
      strb.zeroAcc   = pulse[1] | pulse[2];
    end else if (hitB) begin
      strb.respond   = 1'b1;
      strb.clrExt    = pulse[0];
      strb.chkCoin   = pulse[1];
      strb.zeroAcc   = pulse[1];
      strb.loadExt   = pulse[2];
      strb.orStatus  = pulse[2];
    end else if (hitC) begin
      strb.respond   = 1'b1;
      strb.chkErr    = pulse[0];
      strb.chkDone   = pulse[1] & ~pulse[2];
      strb.zeroAcc   = pulse[1] & pulse[2];
      strb.orDa      = pulse[2];
    end
  end
endmodule

// File: rtl/diskIotPath.sv
module diskIotPath
  import diskIotPkg::*;
#(
  parameter int ACC_W = 12,
  parameter int POS_W = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strb,
  input  logic [ACC_W-1:0] accIn,
  input  logic [POS_W-1:0] rotPos,
  input  logic             photocell,
  input  logic             xferDone,
  input  logic [ERR_W-1:0] errSet,
  output logic             respValid,
  output logic [ACC_W-1:0] accOut,
  output logic             skip,
  output logic             xferStart,
  output logic             xferWrite,
  output logic [ACC_W-1:0] diskAddr,
  output logic [ACC_W-1:0] statusOut,
  output logic             doneFlag,
  output logic             irq
);
  localparam int EXT_MSB = EXT_LSB + EXT_W - 1;

  logic [ACC_W-1:0] daReg, daAfterClr, daNext;
  logic [EXT_W-1:0] extReg, extAfterClr, extNext;
  logic [ERR_W-1:0] errReg, errNext;
  logic             doneReg, doneNext, irqReg, irqNext;
  logic [ACC_W-1:0] oldStatus, accBase, accResult;
  logic             coin, skipNext;

  assign oldStatus   = {photocell, extReg, errReg};
  assign daAfterClr  = strb.clrCtl ? '0 : daReg;
  assign daNext      = strb.loadDa ? (daAfterClr | accIn) : daAfterClr;
  assign accBase     = strb.zeroAcc ? '0 : accIn;
  assign extAfterClr = strb.clrExt ? '0 : extReg;
  assign extNext     = strb.loadExt ? (extAfterClr | accBase[EXT_MSB:EXT_LSB]) : extAfterClr;
  assign accResult   = accBase | (strb.orStatus ? oldStatus : '0) | (strb.orDa ? daReg : '0);
  assign coin        = (daReg[POS_W-1:0] == rotPos);
  assign skipNext    = (strb.chkCoin & coin) | (strb.chkErr & (errReg == '0)) |
                       (strb.chkDone & doneReg);
  assign errNext     = (strb.clrCtl ? '0 : errReg) | errSet;
  assign doneNext    = xferDone ? 1'b1 : (strb.clrCtl ? 1'b0 : doneReg);
  assign irqNext     = xferDone ? 1'b1 : (strb.clrCtl ? 1'b0 : irqReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      daReg     <= '0;
      extReg    <= '0;
      errReg    <= '0;
      doneReg   <= 1'b1;
      irqReg    <= 1'b0;
      respValid <= 1'b0;
      accOut    <= '0;
      skip      <= 1'b0;
      xferStart <= 1'b0;
      xferWrite <= 1'b0;
    end else begin
      daReg     <= daNext;
      extReg    <= extNext;
      errReg    <= errNext;
      doneReg   <= doneNext;
      irqReg    <= irqNext;
      respValid <= strb.respond;
      accOut    <= strb.respond ? accResult : '0;
      skip      <= strb.respond & skipNext;
      xferStart <= strb.startXfer;
      xferWrite <= strb.startXfer & strb.isWrite;
    end
  end

  assign diskAddr  = daReg;
  assign statusOut = oldStatus;
  assign doneFlag  = doneReg;
  assign irq       = irqReg;
endmodule

// File: rtl/diskIotFront.sv
module diskIotFront
  import diskIotPkg::*;
#(
  parameter int ACC_W = 12,
  parameter int POS_W = 11,
  parameter int DEV_W = 6,
  parameter logic [DEV_W-1:0] DEV_A = 6'o60,
  parameter logic [DEV_W-1:0] DEV_B = 6'o61,
  parameter logic [DEV_W-1:0] DEV_C = 6'o62
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               iotStrobe,
  input  logic [DEV_W-1:0]   devCode,
  input  logic [PULSE_W-1:0] pulse,
  input  logic [ACC_W-1:0]   accIn,
  input  logic [POS_W-1:0]   rotPos,
  input  logic               photocell,
  input  logic               xferDone,
  input  logic [ERR_W-1:0]   errSet,
  output logic               respValid,
  output logic [ACC_W-1:0]   accOut,
  output logic               skip,
  output logic               xferStart,
  output logic               xferWrite,
  output logic [ACC_W-1:0]   diskAddr,
  output logic [ACC_W-1:0]   statusOut,
  output logic               doneFlag,
  output logic               irq
);
  ctrlStrobes_t strb;

  diskIotCtrl #(.DEV_W(DEV_W), .DEV_A(DEV_A), .DEV_B(DEV_B), .DEV_C(DEV_C)) uCtrl (
    .iotStrobe(iotStrobe), .devCode(devCode), .pulse(pulse), .strb(strb)
  );

  diskIotPath #(.ACC_W(ACC_W), .POS_W(POS_W)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .accIn(accIn), .rotPos(rotPos),
    .photocell(photocell), .xferDone(xferDone), .errSet(errSet),
    .respValid(respValid), .accOut(accOut), .skip(skip),
    .xferStart(xferStart), .xferWrite(xferWrite), .diskAddr(diskAddr),
    .statusOut(statusOut), .doneFlag(doneFlag), .irq(irq)
  );
endmodule

// File: rtl/diskIotChecker.sv
module diskIotChecker #(
  parameter int DEV_W = 6,
  parameter logic [DEV_W-1:0] DEV_A = 6'o60,
  parameter logic [DEV_W-1:0] DEV_B = 6'o61,
  parameter logic [DEV_W-1:0] DEV_C = 6'o62
) (
  input logic             clk,
  input logic             rstN,
  input logic             iotStrobe,
  input logic [DEV_W-1:0] devCode,
  input logic [2:0]       pulse,
  input logic             xferDone,
  input logic             respValid,
  input logic             skip,
  input logic             accZero,
  input logic             xferStart,
  input logic             doneFlag,
  input logic             irq
);
  logic known;
  assign known = iotStrobe && (devCode == DEV_A || devCode == DEV_B || devCode == DEV_C);

  assert_resp_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    known |=> respValid);
  assert_no_stray_resp_R2: assert property (@(posedge clk) disable iff (!rstN)
    !known |=> !respValid);
  assert_skip_in_resp_R2: assert property (@(posedge clk) disable iff (!rstN)
    skip |-> respValid);
  assert_start_cause_R4: assert property (@(posedge clk) disable iff (!rstN)
    xferStart |-> $past(iotStrobe && devCode == DEV_A && (pulse[1] || pulse[2])));
  assert_coin_zero_acc_R6: assert property (@(posedge clk) disable iff (!rstN)
    (iotStrobe && devCode == DEV_B && pulse == 3'b010) |=> accZero);
  assert_irq_rise_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(xferDone));
  assert_irq_needs_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> doneFlag);
  assert_irq_fall_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irq) |-> $past(iotStrobe && devCode == DEV_A && pulse[0] && !xferDone));
endmodule

bind diskIotFront diskIotChecker #(.DEV_W(DEV_W), .DEV_A(DEV_A), .DEV_B(DEV_B), .DEV_C(DEV_C)) uChk (
  .clk(clk), .rstN(rstN), .iotStrobe(iotStrobe), .devCode(devCode), .pulse(pulse),
  .xferDone(xferDone), .respValid(respValid), .skip(skip), .accZero(accOut == '0),
  .xferStart(xferStart), .doneFlag(doneFlag), .irq(irq)
);

// File: tb/sim_diskIotFront.sv
module sim_diskIotFront;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] CA = 6'o60, CB = 6'o61, CC = 6'o62;

  logic clk = 0, rstN = 0, iotStrobe = 0, photocell = 0, xferDone = 0;
  logic [5:0] devCode = 0;
  logic [2:0] pulse = 0, errSet = 0;
  logic [11:0] accIn = 0;
  logic [10:0] rotPos = 0;
  logic respValid, skip, xferStart, xferWrite, doneFlag, irq;
  logic [11:0] accOut, diskAddr, statusOut;

  int checks = 0, failures = 0, cycles = 0;
  bit finished = 0;

  // reference model state
  int mDa, mExt, mErr, mDone, mIrq, mAcc, mSkip, mResp, mStart, mWrite;

  diskIotFront u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mDa = 0; mExt = 0; mErr = 0; mDone = 1; mIrq = 0;
      mAcc = 0; mSkip = 0; mResp = 0; mStart = 0; mWrite = 0;
    end else begin
      int acc, oldSt, sk, rs, st, wr;
      acc = accIn; sk = 0; rs = 0; st = 0; wr = 0;
      oldSt = (photocell << 11) | (mExt << 3) | mErr;
      if (iotStrobe && devCode == CA) begin
        rs = 1;
        if (pulse[0]) begin mDa = 0; mDone = 0; mErr = 0; mIrq = 0; end
        if (pulse[1] || pulse[2]) begin mDa = mDa | acc; st = 1; wr = pulse[2]; acc = 0; end
      end else if (iotStrobe && devCode == CB) begin
        rs = 1;
        if (pulse[0]) mExt = 0;
        if (pulse[1]) begin acc = 0; sk = ((mDa % 2048) == rotPos); end
        if (pulse[2]) begin mExt = mExt | ((acc >> 3) & 255); acc = acc | oldSt; end
      end else if (iotStrobe && devCode == CC) begin
        rs = 1;
        if (pulse[0] && mErr == 0) sk = 1;
        if (pulse[1]) begin
          if (pulse[2]) acc = 0;
          else if (mDone != 0) sk = 1;
        end
        if (pulse[2]) acc = acc | mDa;
      end
      mErr = mErr | errSet;
      if (xferDone) begin mDone = 1; mIrq = 1; end
      mResp = rs; mAcc = rs ? acc : 0; mSkip = rs ? sk : 0; mStart = st; mWrite = wr;
    end
  end

  // every-cycle comparison, a quarter period after the rising edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (!finished) begin
      int expSt;
      expSt = (photocell << 11) | (mExt << 3) | mErr;
      checks++;
      if (respValid !== mResp[0] || accOut !== mAcc[11:0] || skip !== mSkip[0] ||
          xferStart !== mStart[0] || xferWrite !== mWrite[0] || diskAddr !== mDa[11:0] ||
          statusOut !== expSt[11:0] || doneFlag !== mDone[0] || irq !== mIrq[0]) begin
        failures++;
        $display("FAIL R2 model cycle %0d: act resp=%b acc=%o skip=%b st=%b wr=%b da=%o sts=%o done=%b irq=%b exp resp=%0d acc=%o skip=%0d st=%0d wr=%0d da=%o sts=%o done=%0d irq=%0d",
          cycles, respValid, accOut, skip, xferStart, xferWrite, diskAddr, statusOut, doneFlag, irq,
          mResp, mAcc, mSkip, mStart, mWrite, mDa, expSt, mDone, mIrq);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog: act cycles=%0d exp below 20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: act=%o exp=%o", tag, act, exp);
    end
  endtask

  task automatic iot(input logic [5:0] code, input logic [2:0] p, input logic [11:0] a);
    @(negedge clk);
    iotStrobe = 1; devCode = code; pulse = p; accIn = a;
    @(negedge clk);
    iotStrobe = 0; pulse = 0; accIn = 0;
  endtask

  task automatic complete(input logic [2:0] e);
    @(negedge clk);
    xferDone = 1; errSet = e;
    @(negedge clk);
    xferDone = 0; errSet = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state, sampled with reset still asserted
    chk("R1 diskAddr", diskAddr, 0);
    chk("R1 status", statusOut, 0);
    chk("R1 done", {11'd0, doneFlag}, 1);
    chk("R1 irq", {11'd0, irq}, 0);
    chk("R1 resp/skip/start", {9'd0, respValid, skip, xferStart}, 0);
    rstN = 1;
    @(negedge clk);
    chk("R1 done after release", {11'd0, doneFlag}, 1);

    iot(CA, 3'b010, 12'o0123);
    chk("R4 read load da", diskAddr, 12'o0123);
    chk("R4 start read", {10'd0, xferStart, xferWrite}, 12'b10);
    chk("R4 acc cleared", accOut, 0);
    chk("R2 respValid", {11'd0, respValid}, 1);
    iot(CA, 3'b100, 12'o4000);
    chk("R4 write OR da", diskAddr, 12'o4123);
    chk("R4 start write", {10'd0, xferStart, xferWrite}, 12'b11);
    iot(CA, 3'b011, 12'o0007);
    chk("R4 clear then load", diskAddr, 12'o0007);
    chk("R3 done cleared", {11'd0, doneFlag}, 0);

    complete(3'b100);
    chk("R9 done set", {11'd0, doneFlag}, 1);
    chk("R9 irq set", {11'd0, irq}, 1);
    chk("R9 late error", statusOut, 12'o0004);

    iot(CC, 3'b001, 12'o0);
    chk("R7 no skip with error", {11'd0, skip}, 0);
    iot(CC, 3'b010, 12'o0);
    chk("R8 done skip", {11'd0, skip}, 1);
    iot(CC, 3'b110, 12'o7777);
    chk("R8 2+4 acc=da", accOut, 12'o0007);
    chk("R8 2+4 no skip", {11'd0, skip}, 0);
    iot(CC, 3'b100, 12'o7000);
    chk("R8 OR da", accOut, 12'o7007);

    @(negedge clk); photocell = 1;
    iot(CB, 3'b100, 12'o3770);
    chk("R5 old status returned", accOut, 12'o7774);
    chk("R11 status layout", statusOut, 12'o7774);
    iot(CB, 3'b101, 12'o0100);
    chk("R5 clear then load", statusOut, 12'o4104);
    chk("R5 acc OR old status", accOut, 12'o7774);

    @(negedge clk); rotPos = 11'd7;
    iot(CB, 3'b010, 12'o7777);
    chk("R6 coincidence skip", {11'd0, skip}, 1);
    chk("R6 acc zero", accOut, 0);
    @(negedge clk); rotPos = 11'd8;
    iot(CB, 3'b010, 12'o7777);
    chk("R6 no coincidence", {11'd0, skip}, 0);

    iot(6'o63, 3'b001, 12'o7777);
    chk("R2 unknown code no resp", {11'd0, respValid}, 0);
    chk("R2 unknown code da kept", diskAddr, 12'o0007);
    chk("R10 irq kept", {11'd0, irq}, 1);
    iot(CB, 3'b001, 12'o0);
    chk("R10 irq kept after code B", {11'd0, irq}, 1);

    iot(CA, 3'b001, 12'o0);
    chk("R3 da cleared", diskAddr, 0);
    chk("R3 errors cleared", statusOut & 12'o0007, 0);
    chk("R10 irq cleared", {11'd0, irq}, 0);
    chk("R3 done cleared", {11'd0, doneFlag}, 0);
    iot(CC, 3'b001, 12'o0);
    chk("R7 skip no error", {11'd0, skip}, 1);

    @(negedge clk);
    iotStrobe = 1; devCode = CA; pulse = 3'b001; xferDone = 1;
    @(negedge clk);
    iotStrobe = 0; pulse = 0; xferDone = 0;
    chk("R9 completion wins done", {11'd0, doneFlag}, 1);
    chk("R9 completion wins irq", {11'd0, irq}, 1);

    iot(CA, 3'b010, 12'o4005);
    @(negedge clk); rotPos = 11'd5;
    iot(CB, 3'b010, 12'o0);
    chk("R6 bit 11 ignored", {11'd0, skip}, 1);

    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      iotStrobe = ($urandom_range(0, 2) != 0);
      devCode   = 6'o60 + 6'($urandom_range(0, 3));
      pulse     = 3'($urandom);
      accIn     = 12'($urandom);
      rotPos    = 11'($urandom_range(0, 15));
      photocell = 1'($urandom);
      xferDone  = ($urandom_range(0, 15) == 0);
      errSet    = ($urandom_range(0, 15) == 0) ? 3'($urandom) : 3'b000;
    end
    @(negedge clk);
    iotStrobe = 0; xferDone = 0; errSet = 0;
    repeat (2) @(negedge clk);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule